// File: doc/BRIEF.md
# Reset Domain Controller

This block sits at the reset entry of a PCIe-like endpoint and turns the raw reset causes into one reset output per domain. The causes are the active-low platform reset pin, a main-power-good flag, an auxiliary-power-present flag, a hot-reset indication delivered by the link layer, a secondary-bus-reset control bit, and one function-level reset request bit per function. Each cause reaches a different set of domains. Sticky state follows auxiliary power alone. A platform or power reset clears everything except sticky state. A hot reset clears the logic and the non-sticky configuration space and steers the link state machine through its reset walk. A function-level reset clears a single function and nothing else.

All reset outputs are active high. The platform reset is synchronised by two flops: it asserts asynchronously and releases on the clock. A function-level reset holds its function in reset for a parameterised number of cycles, which is far below the 100 ms completion budget (also a parameter, counted in clock ticks). The function then reports completion with a one-cycle pulse. A wider reset that arrives during a function reset cancels it.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `rst_ni` is low or `main_pwr_good_i` is low, `link_rst_o`, `cfg_rst_o`, `core_rst_o` and every bit of `fn_rst_o` are high, with no clock needed. They are released on the second rising clock edge after both inputs are high.
- R2: `sticky_rst_o` is high while `aux_present_i` is low, with no clock needed. It falls on the second rising edge after `aux_present_i` returns high. No other input affects it.
- R3: After a hot reset starts, `cfg_rst_o`, `core_rst_o` and all `fn_rst_o` bits stay high for as long as `link_cmd_o` is not idle. During that time `link_rst_o` and `sticky_rst_o` stay low.
- R4: A rising edge on `hot_rst_i` sampled at a clock edge while `link_cmd_o` is idle (0) makes `link_cmd_o` step through a fixed sequence, starting in the cycle after that edge: Recovery (1) for one cycle, Hot Reset (2) for `HOT_CYC` cycles, Detect (3) for one cycle, then idle (0).
- R5: `hot_dn_o` equals `sbr_i` delayed by one clock. It is low while R1 holds the block in reset.
- R6: `flr_req_i[k]` high at a clock edge while function k is idle and no wider reset is active makes `fn_rst_o[k]` high for exactly `FLR_CYC` cycles, starting in the next cycle.
- R7: A function-level reset of function k changes no other output. The other `fn_rst_o` bits, `cfg_rst_o`, `core_rst_o`, `link_rst_o`, `sticky_rst_o` and `link_cmd_o` keep their values.
- R8: `flr_done_o[k]` pulses for exactly one cycle, in the cycle right after the last cycle of function k's own reset. This is `FLR_CYC`+1 cycles after the request edge, which is below `FLR_BUDGET`.
- R9: If `cfg_rst_o` (a platform, power or hot reset) is high in any cycle of a function-level reset, including its last, that reset is cancelled and produces no `flr_done_o` pulse.
- R10: A request for function k while function k is already in its own reset is ignored. The reset still ends `FLR_CYC` cycles after the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low platform reset pin |
| aux_present_i | input | 1 | Auxiliary power present |
| main_pwr_good_i | input | 1 | Main power valid |
| hot_rst_i | input | 1 | Hot reset seen by the link layer |
| sbr_i | input | 1 | Secondary-bus-reset control bit |
| flr_req_i | input | N_FN | Per-function reset initiate bit |
| sticky_rst_o | output | 1 | Reset for sticky registers |
| cfg_rst_o | output | 1 | Reset for non-sticky configuration registers |
| core_rst_o | output | 1 | Reset for core logic |
| link_rst_o | output | 1 | Reset for the link state machine |
| link_cmd_o | output | 2 | Link directive: 0 idle, 1 Recovery, 2 Hot Reset, 3 Detect |
| hot_dn_o | output | 1 | Hot reset forwarded downstream |
| fn_rst_o | output | N_FN | Per-function reset |
| flr_done_o | output | N_FN | Per-function completion pulse |

## Verification
The critical collision is a hot reset that starts in the same cycle as a function reset's final cycle. The outcome depends on one cycle of timing. If the hot-reset sequence is already active during that final cycle, the completion pulse must not appear. If it becomes active exactly on the finishing edge, the pulse appears while the wider reset is already high. The bench provokes both cases deterministically by placing `hot_rst_i` one cycle earlier or later against the request. It also sweeps the offset at random. The expected busy length and the presence of the pulse are computed by a bench function from R6, R8 and R9.

// File: rtl/rst_domain_pkg.sv
package rst_domain_pkg;
  typedef enum logic [1:0] {
    LNK_IDLE     = 2'd0,
    LNK_RECOVERY = 2'd1,
    LNK_HOTRST   = 2'd2,
    LNK_DETECT   = 2'd3
  } link_cmd_e;
endpackage

// File: rtl/rst_domain_sync.sv
module rst_domain_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[0], 1'b1};
  end

  assign rst_no = q[1];
endmodule

// File: rtl/rst_domain_hot.sv
module rst_domain_hot
  import rst_domain_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hot_i,
  output link_cmd_e cmd_o,
  output logic      active_o
);
  localparam int unsigned CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  link_cmd_e     cmd_q;
  logic          hot_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= LNK_IDLE;
      hot_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      hot_q <= hot_i;
      unique case (cmd_q)
        LNK_IDLE:     if (hot_i && !hot_q) cmd_q <= LNK_RECOVERY;
        LNK_RECOVERY: begin
          cmd_q <= LNK_HOTRST;
          cnt_q <= '0;
        end
        LNK_HOTRST: begin
          if (cnt_q == LAST) cmd_q <= LNK_DETECT;
          else               cnt_q <= cnt_q + 1'b1;
        end
        LNK_DETECT:   cmd_q <= LNK_IDLE;
        default:      cmd_q <= LNK_IDLE;
      endcase
    end
  end

  assign cmd_o    = cmd_q;
  assign active_o = (cmd_q != LNK_IDLE);
endmodule

// File: rtl/rst_domain_flr.sv
module rst_domain_flr #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        // wider reset wins: drop the sequence silently
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (req_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
  import rst_domain_pkg::*;
#(
  parameter int unsigned N_FN       = 4,
  parameter int unsigned FLR_CYC    = 16,
  parameter int unsigned HOT_CYC    = 4,
  parameter int unsigned FLR_BUDGET = 10_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            aux_present_i,
  input  logic            main_pwr_good_i,
  input  logic            hot_rst_i,
  input  logic            sbr_i,
  input  logic [N_FN-1:0] flr_req_i,
  output logic            sticky_rst_o,
  output logic            cfg_rst_o,
  output logic            core_rst_o,
  output logic            link_rst_o,
  output logic [1:0]      link_cmd_o,
  output logic            hot_dn_o,
  output logic [N_FN-1:0] fn_rst_o,
  output logic [N_FN-1:0] flr_done_o
);
  logic      fund_arst_n, fund_n, aux_n, hot_act, wide, hot_dn_q;
  link_cmd_e link_cmd;
  logic [N_FN-1:0] fn_busy;

  assign fund_arst_n = rst_ni & main_pwr_good_i;

  rst_domain_sync u_fund_sync (.clk_i(clk_i), .arst_ni(fund_arst_n),   .rst_no(fund_n));
  rst_domain_sync u_aux_sync  (.clk_i(clk_i), .arst_ni(aux_present_i), .rst_no(aux_n));

  rst_domain_hot #(.HOLD_CYC(HOT_CYC)) u_hot (
    .clk_i    (clk_i),
    .rst_ni   (fund_n),
    .hot_i    (hot_rst_i),
    .cmd_o    (link_cmd),
    .active_o (hot_act)
  );

  assign wide = ~fund_n | hot_act;

  always_ff @(posedge clk_i or negedge fund_n) begin
    if (!fund_n) hot_dn_q <= 1'b0;
    else         hot_dn_q <= sbr_i;
  end

  for (genvar k = 0; k < N_FN; k++) begin : g_fn
    rst_domain_flr #(.RST_CYC(FLR_CYC)) u_flr (
      .clk_i   (clk_i),
      .rst_ni  (fund_n),
      .req_i   (flr_req_i[k]),
      .abort_i (wide),
      .busy_o  (fn_busy[k]),
      .done_o  (flr_done_o[k])
    );
    assign fn_rst_o[k] = fn_busy[k] | wide;
  end

  assign sticky_rst_o = ~aux_n;
  assign cfg_rst_o    = wide;
  assign core_rst_o   = wide;
  assign link_rst_o   = ~fund_n;
  assign link_cmd_o   = link_cmd;
  assign hot_dn_o     = hot_dn_q;
endmodule

// File: rtl/rst_domain_ctrl_chk.sv
module rst_domain_ctrl_chk
  import rst_domain_pkg::*;
#(
  parameter int unsigned N_FN       = 4,
  parameter int unsigned FLR_BUDGET = 10_000_000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            aux_present_i,
  input logic            main_pwr_good_i,
  input logic            hot_rst_i,
  input logic            sbr_i,
  input logic [N_FN-1:0] flr_req_i,
  input logic            sticky_rst_o,
  input logic            cfg_rst_o,
  input logic            core_rst_o,
  input logic            link_rst_o,
  input logic [1:0]      link_cmd_o,
  input logic            hot_dn_o,
  input logic [N_FN-1:0] fn_rst_o,
  input logic [N_FN-1:0] flr_done_o
);
  p_pwr_fund_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_pwr_good_i |-> (link_rst_o && cfg_rst_o && core_rst_o && (&fn_rst_o)));

  p_sticky_aux_r2: assert property (@(posedge clk_i) disable iff (link_rst_o)
    !aux_present_i |-> sticky_rst_o);

  p_hot_scope_r3: assert property (@(posedge clk_i) disable iff (link_rst_o)
    (link_cmd_o != LNK_IDLE) |-> (cfg_rst_o && core_rst_o && (&fn_rst_o)));

  p_hot_start_r4: assert property (@(posedge clk_i) disable iff (link_rst_o)
    (hot_rst_i && !$past(hot_rst_i) && link_cmd_o == LNK_IDLE) |=> link_cmd_o == LNK_RECOVERY);

  p_rec_next_r4: assert property (@(posedge clk_i) disable iff (link_rst_o)
    (link_cmd_o == LNK_RECOVERY) |=> link_cmd_o == LNK_HOTRST);

  p_det_next_r4: assert property (@(posedge clk_i) disable iff (link_rst_o)
    (link_cmd_o == LNK_DETECT) |=> link_cmd_o == LNK_IDLE);

  p_fwd_r5: assert property (@(posedge clk_i) disable iff (link_rst_o)
    $past(!link_rst_o) |-> hot_dn_o == $past(sbr_i));

  p_no_done_r9: assert property (@(posedge clk_i) disable iff (link_rst_o)
    cfg_rst_o |=> flr_done_o == '0);

  for (genvar k = 0; k < N_FN; k++) begin : g_fn
    logic [31:0] own_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         own_cnt <= '0;
      else if (fn_rst_o[k] && !cfg_rst_o)  own_cnt <= own_cnt + 1;
      else                                 own_cnt <= '0;
    end

    p_start_r6: assert property (@(posedge clk_i) disable iff (link_rst_o)
      (flr_req_i[k] && !fn_rst_o[k]) |=> fn_rst_o[k]);

    p_isolated_r7: assert property (@(posedge clk_i) disable iff (link_rst_o)
      (fn_rst_o[k] && !cfg_rst_o) |-> (link_cmd_o == LNK_IDLE && !core_rst_o));

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (link_rst_o)
      flr_done_o[k] |=> !flr_done_o[k]);

    p_done_after_r8: assert property (@(posedge clk_i) disable iff (link_rst_o)
      flr_done_o[k] |-> $past(fn_rst_o[k]));

    p_budget_r8: assert property (@(posedge clk_i) disable iff (link_rst_o)
      own_cnt < FLR_BUDGET);
  end
endmodule

bind rst_domain_ctrl rst_domain_ctrl_chk #(.N_FN(N_FN), .FLR_BUDGET(FLR_BUDGET)) u_chk (.*);

// File: tb/rst_domain_ctrl_tb.sv
module rst_domain_ctrl_tb;
  localparam int N_FN    = 4;
  localparam int FLR_CYC = 16;
  localparam int HOT_CYC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni, aux_present_i, main_pwr_good_i, hot_rst_i, sbr_i;
  logic [N_FN-1:0] flr_req_i;
  logic            sticky_rst_o, cfg_rst_o, core_rst_o, link_rst_o, hot_dn_o;
  logic [1:0]      link_cmd_o;
  logic [N_FN-1:0] fn_rst_o, flr_done_o;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #5 clk_i = ~clk_i;

  rst_domain_ctrl #(
    .N_FN(N_FN), .FLR_CYC(FLR_CYC), .HOT_CYC(HOT_CYC), .FLR_BUDGET(10_000_000)
  ) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  function automatic int exp_busy(input int hot_at);
    if (hot_at == 0) return FLR_CYC;
    return (hot_at < FLR_CYC) ? hot_at : FLR_CYC;
  endfunction

  function automatic int exp_done(input int hot_at);
    return (hot_at == 0 || hot_at >= FLR_CYC) ? 1 : 0;
  endfunction

  // request function k now; optional repeat at cycle rep_at, hot reset at hot_at
  task automatic run_flr(input int k, input int rep_at, input int hot_at);
    int busy = 0, dones = 0, done_idx = 0, side = 0;
    flr_req_i    = '0;
    flr_req_i[k] = 1'b1;
    for (int i = 1; i <= FLR_CYC + HOT_CYC + 6; i++) begin
      tick();
      if (fn_rst_o[k] && !cfg_rst_o) busy++;
      if (flr_done_o[k]) begin
        dones++;
        done_idx = i;
      end
      for (int j = 0; j < N_FN; j++)
        if (j != k && (fn_rst_o[j] != cfg_rst_o || flr_done_o[j])) side++;
      if (link_rst_o || sticky_rst_o) side++;
      if (!cfg_rst_o && (link_cmd_o != 2'd0 || core_rst_o)) side++;
      flr_req_i    = '0;
      flr_req_i[k] = (i == rep_at);
      hot_rst_i    = (i == hot_at);
    end
    flr_req_i = '0;
    hot_rst_i = 1'b0;
    chk(rep_at != 0 ? "R10 repeat ignored, busy length" : "R6 busy length", busy, exp_busy(hot_at));
    chk(hot_at != 0 ? "R9 done after wider reset" : "R8 done count", dones, exp_done(hot_at));
    if (exp_done(hot_at) == 1) chk("R8 done cycle", done_idx, FLR_CYC + 1);
    chk("R7 other domains untouched", side, 0);
  endtask

  initial begin
    rst_ni = 1'b1; aux_present_i = 1'b1; main_pwr_good_i = 1'b1;
    hot_rst_i = 1'b0; sbr_i = 1'b0; flr_req_i = '0;
    void'($urandom(32'd20240611));
    #2;
    rst_ni = 1'b0; aux_present_i = 1'b0;
    tick();
    chk("R1 reset link", link_rst_o, 1);
    chk("R1 reset cfg", cfg_rst_o, 1);
    chk("R1 reset core", core_rst_o, 1);
    chk("R1 reset fn", fn_rst_o, (1 << N_FN) - 1);
    chk("R2 reset sticky", sticky_rst_o, 1);
    chk("R8 no done in reset", flr_done_o, 0);
    chk("R4 idle in reset", link_cmd_o, 0);
    chk("R5 no forward in reset", hot_dn_o, 0);

    rst_ni = 1'b1; aux_present_i = 1'b1;
    tick();
    chk("R1 held one edge", link_rst_o, 1);
    chk("R2 held one edge", sticky_rst_o, 1);
    tick();
    chk("R1 released", link_rst_o, 0);
    chk("R1 cfg released", cfg_rst_o, 0);
    chk("R1 fn released", fn_rst_o, 0);
    chk("R2 released", sticky_rst_o, 0);

    // warm reset with aux present
    rst_ni = 1'b0;
    #1;
    chk("R1 async assert", link_rst_o, 1);
    chk("R1 async fn", fn_rst_o, (1 << N_FN) - 1);
    chk("R2 sticky kept on warm reset", sticky_rst_o, 0);
    tick(); rst_ni = 1'b1; tick(); tick();
    chk("R1 warm release", link_rst_o, 0);

    // main power drop
    main_pwr_good_i = 1'b0;
    #1;
    chk("R1 power drop cfg", cfg_rst_o, 1);
    chk("R1 power drop link", link_rst_o, 1);
    chk("R2 sticky kept on power drop", sticky_rst_o, 0);
    tick(); main_pwr_good_i = 1'b1; tick(); tick();
    chk("R1 power release", cfg_rst_o, 0);

    // aux loss alone
    aux_present_i = 1'b0;
    #1;
    chk("R2 aux loss sticky", sticky_rst_o, 1);
    chk("R2 aux loss cfg untouched", cfg_rst_o, 0);
    tick(); aux_present_i = 1'b1; tick(); tick();
    chk("R2 aux return", sticky_rst_o, 0);

    // downstream forward
    sbr_i = 1'b1; tick();
    chk("R5 forward high", hot_dn_o, 1);
    chk("R5 forward no local reset", cfg_rst_o, 0);
    sbr_i = 1'b0; tick();
    chk("R5 forward low", hot_dn_o, 0);

    // hot reset walk
    hot_rst_i = 1'b1; tick();
    chk("R4 recovery", link_cmd_o, 1);
    chk("R3 cfg in hot", cfg_rst_o, 1);
    chk("R3 core in hot", core_rst_o, 1);
    chk("R3 fn in hot", fn_rst_o, (1 << N_FN) - 1);
    chk("R3 link kept", link_rst_o, 0);
    chk("R3 sticky kept", sticky_rst_o, 0);
    hot_rst_i = 1'b0;
    begin
      int n_hot = 0;
      for (int i = 0; i < HOT_CYC; i++) begin
        tick();
        if (link_cmd_o == 2'd2) n_hot++;
      end
      chk("R4 hot reset length", n_hot, HOT_CYC);
    end
    tick();
    chk("R4 detect", link_cmd_o, 3);
    tick();
    chk("R4 back to idle", link_cmd_o, 0);
    chk("R3 cfg released after walk", cfg_rst_o, 0);

    // directed function resets
    run_flr(0, 0, 0);
    run_flr(N_FN - 1, 3, 0);
    run_flr(1, FLR_CYC, 0);
    run_flr(1, 0, FLR_CYC - 1);  // hot active in last busy cycle: no done
    run_flr(2, 0, FLR_CYC);      // hot starts on finishing edge: done
    run_flr(3, 0, 1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int k    = $urandom_range(N_FN - 1, 0);
      int mode = $urandom_range(2, 0);
      int gap  = $urandom_range(3, 0);
      for (int g = 0; g < gap; g++) tick();
      run_flr(k, (mode == 1) ? $urandom_range(FLR_CYC, 1) : 0,
                 (mode == 2) ? $urandom_range(FLR_CYC + 2, 1) : 0);
    end

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!fin) begin
      bad++;
      total++;
      $display("FAIL watchdog (all): actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule